// File: doc/BRIEF.md
# 18-bit stack-core arithmetic unit with multiply step

This unit is the arithmetic engine of a small stack processor. Each operation reads the top-of-stack value T and the second value S. The shift-add multiply step also reads a multiplier value A. A caller raises `start` for one cycle with a 5-bit operation code. The unit answers with an 18-bit result and a one-cycle `done` pulse.

Inversion, the two shifts and unknown codes complete in a single clock. Add and the multiply step split the 18-bit carry chain into two halves, one half per clock, so they take two clocks. During the first of those clocks `busy` is high.

The multiply step also returns the next S (shifted left) and the next A (shifted right). A controller that feeds `result`, `s_out` and `a_out` back as T, S and A for 18 steps, starting from T = 0, obtains the low 18 bits of S times A.

Top module: `stk_alu`

## Requirements
- R1: Code 5'h00 returns the bitwise inverse of T. `done` is high and `busy` low in the cycle after the accepting clock edge.
- R2: Code 5'h01 returns T shifted left by one with a zero in bit 0, in one cycle.
- R3: Code 5'h02 returns T shifted right by one with a zero in bit 17 (logical shift), in one cycle.
- R4: Code 5'h03 returns (T + S) mod 2^18. `busy` is high, and `done` low, in the cycle after the accepting edge. `done` is high, and `busy` low, one cycle later.
- R5: `carry` takes the carry-out of bit 17 when an add completes. No other operation changes it.
- R6: Code 5'h04 returns T + S (mod 2^18) when A[0] is 1, and T otherwise, with the same two-cycle timing as add. On completion `s_out` is S shifted left by one and `a_out` is A shifted right by one (logical). Every other operation leaves `s_out` and `a_out` unchanged.
- R7: Eighteen chained code 5'h04 steps, starting from T = 0, yield (S × A) mod 2^18 in `result`. Each step uses the previous `result`, `s_out` and `a_out` as T, S and A.
- R8: Any code from 5'h05 to 5'h1F returns T unchanged, in one cycle.
- R9: A `start` that arrives while `busy` is high is ignored. The operation in flight completes with its own code and operands.
- R10: A synchronous, active-high `rst` clears `result`, `s_out`, `a_out`, `carry`, `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken when not busy) |
| op | input | 5 | Operation code |
| t_in | input | 18 | Top-of-stack operand T |
| s_in | input | 18 | Second operand S |
| a_in | input | 18 | Multiplier operand A |
| result | output | 18 | Operation result |
| s_out | output | 18 | Next S after a multiply step |
| a_out | output | 18 | Next A after a multiply step |
| carry | output | 1 | Carry-out of the last add |
| busy | output | 1 | First cycle of a two-cycle operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
For inversion, the shifts and unknown codes, `result` and `done` are due one clock edge after the edge that accepts `start`. For add and the multiply step, `busy` is due after the first edge and `result`, `done`, `carry`, `s_out` and `a_out` after the second. The bench drives inputs on falling edges and samples on the following falling edges. It therefore checks `busy` at the first sample point and the results at the second. While `busy` is high it sometimes presents a conflicting `start`, to show that the operation in flight completes with its own code and operands.

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W   = 18,
  parameter int OPW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   t_in,
  input  logic [W-1:0]   s_in,
  input  logic [W-1:0]   a_in,
  output logic [W-1:0]   result,
  output logic [W-1:0]   s_out,
  output logic [W-1:0]   a_out,
  output logic           carry,
  output logic           busy,
  output logic           done
);
  localparam int LO = W / 2;
  localparam int HI = W - LO;
  localparam logic [OPW-1:0] OP_INV = OPW'(0);
  localparam logic [OPW-1:0] OP_SHL = OPW'(1);
  localparam logic [OPW-1:0] OP_SHR = OPW'(2);
  localparam logic [OPW-1:0] OP_ADD = OPW'(3);
  localparam logic [OPW-1:0] OP_SAD = OPW'(4);

  logic          two_cyc;
  logic [W-1:0]  addend;
  logic [LO:0]   lo_sum;
  logic [HI:0]   hi_sum;
  logic [W-1:0]  single;
  logic [LO-1:0] lo_q;
  logic          cy_q;
  logic [HI-1:0] th_q, ah_q;
  logic          is_add_q;
  logic [W-1:0]  s_nx, a_nx;

  assign two_cyc = (op == OP_ADD) || (op == OP_SAD);
  assign addend  = (op == OP_SAD && !a_in[0]) ? '0 : s_in;
  assign lo_sum  = {1'b0, t_in[LO-1:0]} + {1'b0, addend[LO-1:0]};
  assign hi_sum  = {1'b0, th_q} + {1'b0, ah_q} + {{HI{1'b0}}, cy_q};

  always_comb begin
    case (op)
      OP_INV:  single = ~t_in;
      OP_SHL:  single = {t_in[W-2:0], 1'b0};
      OP_SHR:  single = {1'b0, t_in[W-1:1]};
      default: single = t_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      s_out    <= '0;
      a_out    <= '0;
      carry    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      lo_q     <= '0;
      cy_q     <= 1'b0;
      th_q     <= '0;
      ah_q     <= '0;
      is_add_q <= 1'b0;
      s_nx     <= '0;
      a_nx     <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= {hi_sum[HI-1:0], lo_q};
        if (is_add_q) begin
          carry <= hi_sum[HI];
        end else begin
          s_out <= s_nx;
          a_out <= a_nx;
        end
      end else if (start) begin
        if (two_cyc) begin
          busy     <= 1'b1;
          lo_q     <= lo_sum[LO-1:0];
          cy_q     <= lo_sum[LO];
          th_q     <= t_in[W-1:LO];
          ah_q     <= addend[W-1:LO];
          is_add_q <= (op == OP_ADD);
          s_nx     <= {s_in[W-2:0], 1'b0};
          a_nx     <= {1'b0, a_in[W-1:1]};
        end else begin
          result <= single;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stk_alu_chk.sv
module stk_alu_chk #(
  parameter int W   = 18,
  parameter int OPW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [OPW-1:0] op,
  input logic [W-1:0]   t_in,
  input logic [W-1:0]   s_in,
  input logic [W-1:0]   a_in,
  input logic [W-1:0]   result,
  input logic [W-1:0]   s_out,
  input logic [W-1:0]   a_out,
  input logic           carry,
  input logic           busy,
  input logic           done
);
  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && s_out == '0 && a_out == '0 && !carry && !busy && !done));

  // R4
  busy_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done && !busy));

  // R9
  start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> !busy);

  // R5
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(carry));

  // R1
  inv_result_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == OPW'(0)) |=> (done && !busy && result == ~$past(t_in)));

  // R8
  pass_result_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op > OPW'(4)) |=> (done && result == $past(t_in)));

  // R6
  side_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(s_out) && $stable(a_out)));
endmodule

bind stk_alu stk_alu_chk #(.W(W), .OPW(OPW)) chk_i (.*);

// File: tb/tb_stk_alu.sv
module tb_stk_alu;
  localparam int W = 18;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [4:0] op = '0;
  logic [W-1:0] t_in = '0, s_in = '0, a_in = '0;
  logic [W-1:0] result, s_out, a_out;
  logic carry, busy, done;

  int ncmp = 0;
  int nbad = 0;
  logic exp_carry = 1'b0;
  logic [W-1:0] exp_s = '0, exp_a = '0;

  always #5 clk = ~clk;

  stk_alu dut (.clk(clk), .rst(rst), .start(start), .op(op), .t_in(t_in), .s_in(s_in),
               .a_in(a_in), .result(result), .s_out(s_out), .a_out(a_out),
               .carry(carry), .busy(busy), .done(done));

  function automatic logic [W-1:0] model(input logic [4:0] o, input logic [W-1:0] t,
                                         input logic [W-1:0] s, input logic [W-1:0] a);
    case (o)
      5'h00: return ~t;
      5'h01: return {t[W-2:0], 1'b0};
      5'h02: return {1'b0, t[W-1:1]};
      5'h03: return t + s;
      5'h04: return a[0] ? t + s : t;
      default: return t;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    ncmp++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  endtask

  task automatic run(input logic [4:0] o, input logic [W-1:0] t, input logic [W-1:0] s,
                     input logic [W-1:0] a, input bit poke, input string tag);
    logic [W-1:0] e;
    logic [W+1:0] wide;
    bit two;
    two = (o == 5'h03) || (o == 5'h04);
    e = model(o, t, s, a);
    @(negedge clk);
    start = 1'b1; op = o; t_in = t; s_in = s; a_in = a;
    @(negedge clk);
    start = 1'b0;
    if (two) begin
      chk({tag, " busy (R4)"}, {31'd0, busy}, 32'd1);
      chk({tag, " early done (R4)"}, {31'd0, done}, 32'd0);
      if (poke) begin
        start = 1'b1; op = 5'h00; t_in = $urandom; s_in = $urandom; a_in = $urandom;
      end
      @(negedge clk);
      start = 1'b0;
      if (o == 5'h03) begin
        wide = {2'b0, t} + {2'b0, s};
        exp_carry = wide[W];
      end else begin
        exp_s = {s[W-2:0], 1'b0};
        exp_a = {1'b0, a[W-1:1]};
      end
    end
    chk({tag, " done"}, {31'd0, done}, 32'd1);
    chk({tag, " busy low"}, {31'd0, busy}, 32'd0);
    chk({tag, " result"}, {14'd0, result}, {14'd0, e});
    chk({tag, " carry (R5)"}, {31'd0, carry}, {31'd0, exp_carry});
    chk({tag, " side outputs (R6)"}, {s_out, a_out} >> 4, {exp_s, exp_a} >> 4);
  endtask

  task automatic multiply(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    logic [W-1:0] t, s, a;
    logic [2*W-1:0] full;
    run(5'h04, '0, x, y, 1'b0, {tag, " R7 step"});
    for (int k = 1; k < W; k++) begin
      t = result; s = s_out; a = a_out;
      run(5'h04, t, s, a, (k % 5) == 0, {tag, " R7 step"});
    end
    full = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    chk({tag, " R7 product"}, {14'd0, result}, {14'd0, full[W-1:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 result reset", {14'd0, result}, 32'd0);
    chk("R10 flags reset", {29'd0, carry, busy, done}, 32'd0);
    chk("R10 side reset", {s_out, a_out} >> 4, 32'd0);

    run(5'h00, 18'h00000, 0, 0, 0, "R1 inv zero");
    run(5'h00, 18'h2A5C3, 0, 0, 0, "R1 inv pattern");
    run(5'h01, 18'h20001, 0, 0, 0, "R2 shl msb drop");
    run(5'h02, 18'h20001, 0, 0, 0, "R3 shr lsb drop");
    run(5'h03, MASK, 18'h00001, 0, 0, "R4 add wrap");
    run(5'h03, 18'h001FF, 18'h00001, 0, 0, "R4 add mid carry");
    run(5'h01, MASK, 0, 0, 0, "R5 shl keeps carry");
    run(5'h04, 18'h3FFFF, 18'h00002, 18'h00001, 0, "R6 sad a0 set overflow");
    run(5'h04, 18'h12345, 18'h3FFFF, 18'h3FFFE, 0, "R6 sad a0 clear");
    run(5'h03, 18'h00010, 18'h00020, 0, 1, "R9 add poked");
    run(5'h04, 18'h00100, 18'h00200, 18'h00003, 1, "R9 sad poked");
    run(5'h05, 18'h1ABCD, 0, 0, 0, "R8 code 05");
    run(5'h1F, 18'h3C3C3, 0, 0, 0, "R8 code 1f");

    multiply(18'h3FFFF, 18'h3FFFF, "mul max");
    multiply(18'h00000, 18'h2ABCD, "mul zero");
    multiply(18'h00001, 18'h31415, "mul one");

    for (int i = 0; i < 200; i++) begin
      logic [4:0] o;
      o = 5'($urandom_range(0, 31));
      if (i % 3 == 0) o = 5'($urandom_range(0, 4));
      run(o, W'($urandom), W'($urandom), W'($urandom), ($urandom % 4) == 0, "rand R1 R2 R3 R4 R6 R8");
    end
    for (int i = 0; i < 12; i++)
      multiply(W'($urandom), W'($urandom), "rand mul");

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_carry = 1'b0; exp_s = '0; exp_a = '0;
    chk("R10 mid reset result", {14'd0, result}, 32'd0);
    chk("R10 mid reset flags", {29'd0, carry, busy, done}, 32'd0);
    report();
  end
endmodule